// File: doc/BRIEF.md
# Continuous Dual-Channel Serial Sample Receiver

This block listens to a two-channel serial converter that runs on its own: chip select is held low and a free oscillator drives the serial clock. The converter sends one frame per conversion. Each frame has 33 serial clocks. Thirty-two of them carry data, and the remaining clock is idle. A conversion-status line is high while the 32 data bits are shifted out. It drops after the last data clock and rises again after the idle clock. The receiver never drives the link. It only samples the serial clock, the data line and the status line.

All three inputs pass through a synchronizer into the faster system clock domain. The receiver detects edges on the synchronized serial clock and on the synchronized status line. It uses the status edges, not a chip select, to find where each frame starts and ends. Both channel results are extracted from the frame and presented together with a one-cycle valid strobe, and a count of good frames is kept.

The receiver checks every frame for the right length and for zero padding. A frame that fails either check raises a loss-of-lock pulse. The receiver then relocks by observing one full status-high interval.

Top module: `stream_rx_top`

## Requirements
- R1: While `rstN` is low and in the first cycle after it, `sampleValid`, `syncLost` and `locked` are 0, and `sampleA`, `sampleB` and `frameCount` are all zero.
- R2: After reset the receiver is unlocked. The bits of the first status-high interval are discarded and produce no `sampleValid`. `locked` rises only after that interval ends.
- R3: While status is high, one data bit is taken on each rising serial clock edge, MSB first. Of the 32 bits, bits 1 to 4 are padding and bits 5 to 16 are channel A. Bits 17 to 20 are padding and bits 21 to 32 are channel B. Channel A appears on `sampleA` and channel B on `sampleB`.
- R4: For each good frame, `sampleValid` is high for exactly one system cycle, a few cycles after status falls. The samples stay on the ports until the next good frame.
- R5: `frameCount` goes up by one with every `sampleValid` pulse and wraps modulo 2^COUNT_W.
- R6: Serial clock edges that occur while status is low, including the idle clock and any extra clocks, have no effect on the reported samples.
- R7: If a status-high interval holds a number of rising serial clock edges other than 32, then when status falls `syncLost` pulses for one cycle, `locked` drops, and no `sampleValid` is produced.
- R8: If any padding bit of a frame (bits 1 to 4 or bits 17 to 20) is 1, the frame is treated as in R7.
- R9: After a loss of lock, the next status-high interval is discarded to relock. The frame after that one is reported normally.
- R10: A rejected or discarded frame leaves `sampleA`, `sampleB` and `frameCount` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than the serial clock |
| rstN | input | 1 | Active-low synchronous reset |
| serClk | input | 1 | Serial clock from the converter, asynchronous to clk |
| serData | input | 1 | Serial data, stable around rising serial clock edges |
| convStatus | input | 1 | Conversion status, high while a frame's data bits are sent |
| sampleValid | output | 1 | One-cycle strobe marking new samples |
| sampleA | output | SAMPLE_W (12) | Latest channel A result |
| sampleB | output | SAMPLE_W (12) | Latest channel B result |
| frameCount | output | COUNT_W (16) | Number of good frames, wrapping |
| locked | output | 1 | High while the receiver is aligned to frames |
| syncLost | output | 1 | One-cycle pulse when a frame is rejected |

## Verification
The hardest condition to reach from the ports is the recovery sequence after a bad frame. It needs a short, long or badly padded frame, then a discarded relock frame, and only then a good frame. Sample and counter values must stay untouched through both bad frames. The stimulus injects frames of 31 and 33 bits and frames with a set padding bit in the middle of a random stream. After each injection it checks that two more frames are needed before samples flow again. Extra serial clocks with random data are sent during the idle gap to show that bits outside the status window are ignored.

// File: rtl/rxstream_pkg.sv
package rxstream_pkg;

  // Number of channels carried in one frame (A first, then B)
  localparam int NUM_CHAN = 2;

  // Strobes from control to datapath
  typedef struct packed {
    logic frameStart;  // status rose: clear the shift register
    logic shiftEn;     // take one data bit
    logic emit;        // frame accepted: publish the samples
  } rxStrobe_t;

  typedef enum logic [1:0] {
    ST_HUNT  = 2'd0,   // waiting for a status rise
    ST_PRIME = 2'd1,   // inside the alignment interval, bits discarded
    ST_TRACK = 2'd2    // aligned, frames are counted and checked
  } rxState_e;

endpackage

// File: rtl/sync_chain.sv
module sync_chain #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stage [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rstN) stage[0] <= '0;
        else       stage[0] <= asyncIn;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rstN) stage[s] <= '0;
        else       stage[s] <= stage[s-1];
      end
    end
  end

  assign syncOut = stage[STAGES-1];

endmodule

// File: rtl/rx_ctrl.sv
module rx_ctrl
  import rxstream_pkg::*;
#(
  parameter int FRAME_BITS = 32
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      serClkLvl,
  input  logic      statusLvl,
  input  logic      padZero,
  output rxStrobe_t strobe,
  output logic      locked,
  output logic      syncLost
);

  localparam int CNT_W = $clog2(FRAME_BITS + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_BITS + 1);

  rxState_e         state, stateNext;
  logic             clkPrev, statPrev;
  logic             bitRise, statRise, statFall;
  logic [CNT_W-1:0] bitCnt;
  logic             frameDone, frameGood;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      clkPrev  <= 1'b0;
      statPrev <= 1'b0;
    end else begin
      clkPrev  <= serClkLvl;
      statPrev <= statusLvl;
    end
  end

  always_comb begin
    bitRise   = serClkLvl & ~clkPrev;
    statRise  = statusLvl & ~statPrev;
    statFall  = ~statusLvl & statPrev;
    frameDone = (state == ST_TRACK) && statFall;
    frameGood = (bitCnt == CNT_FULL) && padZero;
    strobe.frameStart = statRise;
    strobe.shiftEn    = bitRise & statusLvl;
    strobe.emit       = frameDone & frameGood;
  end

  // Bit counter saturates one past a full frame so long frames stay detectable
  always_ff @(posedge clk) begin
    if (!rstN)                                  bitCnt <= '0;
    else if (statRise)                          bitCnt <= '0;
    else if (strobe.shiftEn && bitCnt != CNT_SAT) bitCnt <= bitCnt + 1'b1;
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_HUNT:  if (statRise) stateNext = ST_PRIME;
      ST_PRIME: if (statFall) stateNext = ST_TRACK;
      ST_TRACK: if (frameDone && !frameGood) stateNext = ST_HUNT;
      default:  stateNext = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_HUNT;
      syncLost <= 1'b0;
    end else begin
      state    <= stateNext;
      syncLost <= frameDone & ~frameGood;
    end
  end

  assign locked = (state == ST_TRACK);

  // R7
  lost_unlock_chk: assert property (@(posedge clk) disable iff (!rstN)
    syncLost |-> !locked);

  // R2
  lock_after_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(locked) |-> $past(statFall));

  // R6
  idle_cnt_chk: assert property (@(posedge clk) disable iff (!rstN)
    !statusLvl |=> $stable(bitCnt));

  // R7
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_SAT);

endmodule

// File: rtl/rx_datapath.sv
module rx_datapath
  import rxstream_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int PAD_W    = 4,
  parameter int COUNT_W  = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                dataLvl,
  input  rxStrobe_t           strobe,
  output logic                padZero,
  output logic [SAMPLE_W-1:0] sampleA,
  output logic [SAMPLE_W-1:0] sampleB,
  output logic                sampleValid,
  output logic [COUNT_W-1:0]  frameCount
);

  localparam int SLOT_W     = PAD_W + SAMPLE_W;
  localparam int FRAME_BITS = NUM_CHAN * SLOT_W;

  logic [FRAME_BITS-1:0] shiftReg;
  logic [NUM_CHAN-1:0]   padBits;
  logic [SAMPLE_W-1:0]   sampleReg [NUM_CHAN];

  always_ff @(posedge clk) begin
    if (!rstN)                 shiftReg <= '0;
    else if (strobe.frameStart) shiftReg <= '0;
    else if (strobe.shiftEn)    shiftReg <= {shiftReg[FRAME_BITS-2:0], dataLvl};
  end

  // Channel 0 (A) occupies the most significant slot: it arrives first
  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
    localparam int SLOT_LSB = (NUM_CHAN - 1 - c) * SLOT_W;
    assign padBits[c] = |shiftReg[SLOT_LSB + SAMPLE_W +: PAD_W];
    always_ff @(posedge clk) begin
      if (!rstN)            sampleReg[c] <= '0;
      else if (strobe.emit) sampleReg[c] <= shiftReg[SLOT_LSB +: SAMPLE_W];
    end
  end

  assign padZero = ~|padBits;
  assign sampleA = sampleReg[0];
  assign sampleB = sampleReg[1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sampleValid <= 1'b0;
      frameCount  <= '0;
    end else begin
      sampleValid <= strobe.emit;
      if (strobe.emit) frameCount <= frameCount + 1'b1;
    end
  end

  // R4
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> !sampleValid);

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |-> ($stable(sampleA) && $stable(sampleB) && $stable(frameCount)));

  // R5
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |-> frameCount == COUNT_W'($past(frameCount) + 1'b1));

endmodule

// File: rtl/stream_rx_top.sv
module stream_rx_top
  import rxstream_pkg::*;
#(
  parameter int SAMPLE_W    = 12,
  parameter int PAD_W       = 4,
  parameter int COUNT_W     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                serClk,
  input  logic                serData,
  input  logic                convStatus,
  output logic                sampleValid,
  output logic [SAMPLE_W-1:0] sampleA,
  output logic [SAMPLE_W-1:0] sampleB,
  output logic [COUNT_W-1:0]  frameCount,
  output logic                locked,
  output logic                syncLost
);

  localparam int FRAME_BITS = NUM_CHAN * (PAD_W + SAMPLE_W);

  logic [2:0] syncIn, syncOut;
  rxStrobe_t  strobe;
  logic       padZero;

  assign syncIn = {convStatus, serData, serClk};

  sync_chain #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (syncIn),
    .syncOut (syncOut)
  );

  rx_ctrl #(.FRAME_BITS(FRAME_BITS)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .serClkLvl (syncOut[0]),
    .statusLvl (syncOut[2]),
    .padZero   (padZero),
    .strobe    (strobe),
    .locked    (locked),
    .syncLost  (syncLost)
  );

  rx_datapath #(.SAMPLE_W(SAMPLE_W), .PAD_W(PAD_W), .COUNT_W(COUNT_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .dataLvl     (syncOut[1]),
    .strobe      (strobe),
    .padZero     (padZero),
    .sampleA     (sampleA),
    .sampleB     (sampleB),
    .sampleValid (sampleValid),
    .frameCount  (frameCount)
  );

  // R7
  excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(sampleValid && syncLost));

  // R4
  valid_locked_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |-> locked);

endmodule

// File: tb/sim_stream_rx_top.sv
module sim_stream_rx_top;

  localparam int CLK_NS   = 10;
  localparam int HALF_SER = 4;
  localparam int CW       = 4;

  logic clk = 1'b0, rstN = 1'b0;
  logic serClk = 1'b0, serData = 1'b0, convStatus = 1'b0;
  logic sampleValid, locked, syncLost;
  logic [11:0] sampleA, sampleB;
  logic [CW-1:0] frameCount;

  int checks = 0, failures = 0;
  int validSeen = 0, lostSeen = 0;
  bit done = 1'b0;
  logic [11:0] expA = '0, expB = '0;
  int expCnt = 0;

  stream_rx_top #(.COUNT_W(CW)) u0 (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData),
    .convStatus(convStatus), .sampleValid(sampleValid), .sampleA(sampleA),
    .sampleB(sampleB), .frameCount(frameCount), .locked(locked), .syncLost(syncLost)
  );

  always #(CLK_NS/2) clk = ~clk;

  always @(negedge clk) begin
    if (sampleValid) validSeen++;
    if (syncLost)    lostSeen++;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic serCycle(input logic d);
    serData = d;
    tick(2);
    serClk = 1'b1;
    tick(HALF_SER);
    serClk = 1'b0;
    tick(2);
  endtask

  function automatic logic [31:0] mkWord(input logic [11:0] a, input logic [11:0] b);
    return {4'b0000, a, 4'b0000, b};
  endfunction

  // idle clocks with random data, status high window, nbits data clocks
  task automatic sendFrame(input logic [31:0] word, input int nbits, input int extraDead);
    for (int k = 0; k < 1 + extraDead; k++) serCycle(1'($urandom_range(0, 1)));
    tick(2);
    convStatus = 1'b1;
    tick(2);
    for (int i = 0; i < nbits; i++) serCycle(i < 32 ? word[31-i] : 1'b1);
    tick(2);
    convStatus = 1'b0;
    tick(12);
  endtask

  task automatic goodFrame(input logic [11:0] a, input logic [11:0] b, input int extraDead,
                           input string req);
    int v0, l0;
    v0 = validSeen; l0 = lostSeen;
    sendFrame(mkWord(a, b), 32, extraDead);
    expA = a; expB = b; expCnt = (expCnt + 1) % (1 << CW);
    chk(req, "valid pulses", validSeen - v0, 1);
    chk(req, "lost pulses", lostSeen - l0, 0);
    chk(req, "sampleA", int'(sampleA), int'(expA));
    chk(req, "sampleB", int'(sampleB), int'(expB));
    chk("R5", "frameCount", int'(frameCount), expCnt);
  endtask

  // bad frame followed by a discarded relock frame (R7/R8, R9, R10)
  task automatic badFrame(input logic [31:0] word, input int nbits, input string req);
    int v0, l0;
    v0 = validSeen; l0 = lostSeen;
    sendFrame(word, nbits, 0);
    chk(req, "lost pulses", lostSeen - l0, 1);
    chk(req, "valid pulses", validSeen - v0, 0);
    chk(req, "locked", int'(locked), 0);
    chk("R10", "sampleA held", int'(sampleA), int'(expA));
    chk("R10", "sampleB held", int'(sampleB), int'(expB));
    chk("R10", "frameCount held", int'(frameCount), expCnt);
    v0 = validSeen; l0 = lostSeen;
    sendFrame(mkWord(12'h5A5, 12'hA5A), 32, 0);
    chk("R9", "relock frame valid", validSeen - v0, 0);
    chk("R9", "relock frame lost", lostSeen - l0, 0);
    chk("R9", "locked after relock", int'(locked), 1);
    chk("R10", "frameCount after relock", int'(frameCount), expCnt);
    goodFrame(12'(word[27:16] ^ 12'hFFF), 12'(word[11:0] ^ 12'h0F0), 0, "R9");
  endtask

  initial begin
    void'($urandom(32'd2024));
    tick(5);
    chk("R1", "valid in reset", int'(sampleValid), 0);
    chk("R1", "locked in reset", int'(locked), 0);
    chk("R1", "syncLost in reset", int'(syncLost), 0);
    chk("R1", "sampleA in reset", int'(sampleA), 0);
    chk("R1", "frameCount in reset", int'(frameCount), 0);
    rstN = 1'b1;
    tick(1);
    chk("R1", "sampleB after reset", int'(sampleB), 0);
    tick(3);

    // R2: first interval only primes the receiver
    begin
      int v0;
      v0 = validSeen;
      chk("R2", "locked before first interval", int'(locked), 0);
      sendFrame(mkWord(12'h123, 12'h456), 32, 0);
      chk("R2", "no valid from priming frame", validSeen - v0, 0);
      chk("R2", "locked after first interval", int'(locked), 1);
      chk("R2", "sampleA untouched", int'(sampleA), 0);
    end

    goodFrame(12'hFFF, 12'h000, 0, "R3");
    goodFrame(12'h800, 12'h001, 3, "R6");
    goodFrame(12'h001, 12'hFFF, 2, "R4");

    for (int n = 0; n < 14; n++)
      goodFrame(12'($urandom), 12'($urandom), $urandom_range(0, 3), "R3");

    badFrame(mkWord(12'h3C3, 12'h777), 31, "R7");
    badFrame(mkWord(12'h0F0, 12'h111), 33, "R7");
    badFrame(mkWord(12'hABC, 12'hDEF) | 32'h2000_0000, 32, "R8");
    badFrame(mkWord(12'h246, 12'h8AC) | 32'h0000_2000, 32, "R8");

    for (int n = 0; n < 6; n++)
      goodFrame(12'($urandom), 12'($urandom), $urandom_range(0, 3), "R5");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule